// File: doc/BRIEF.md
# Serial Flash Chip-Erase Sequencer

This block is the host side of an SPI link to a serial NOR flash. It carries out one complete whole-array erase for each start request. First it sends the write-enable command (0x06) in a transaction of its own. Then it sends the erase opcode alone in a second transaction, and raising CE at the end of that byte starts the erase inside the flash. Last, it opens a single read-status transaction (0x05) and keeps clocking status bytes inside it until bit 0 (Busy) reads 0. CE is released at the end of each of these transactions.

SCK is derived from the system clock by a parameterised divider. The idle level of SCK follows SPI mode 0 or mode 3, and in both modes data leave MSB first. CE is kept high for a programmable minimum number of cycles after each transaction. A poll limit bounds the wait: once it is reached, the sequence ends with a timeout flag. Each sequence, whether it ends normally or by timeout, finishes with a one-cycle done pulse.

Top module: `flash_erase_seq`

## Requirements
- R1: A start pulse seen in idle produces exactly three CE-low transactions, in this order: write-enable alone, then the erase opcode alone, then read-status followed by status bytes.
- R2: Bytes go out on SI MSB first. Write-enable is 0x06, read-status is 0x05, and the erase byte equals the parameter ERASE_OP (0x60 or 0xC7).
- R3: Between two transactions of a sequence, and between the last release of CE and the done pulse, CE stays high for at least GAP_CYC system clock cycles.
- R4: The status poll stays inside one transaction. Bit 0 of each status byte is Busy (1 = busy). The transaction ends after the first status byte that has bit 0 clear, so a flash that reports busy B times yields B+1 status bytes.
- R5: If POLL_LIMIT status bytes all read busy, CE is released after the last of them and timeout is asserted together with done.
- R6: done is high for exactly one cycle per sequence. timeout is high only in a cycle where done is high, and only when the poll limit was reached.
- R7: A start pulse that arrives while a sequence is in progress is ignored. It produces no extra transaction and no extra done.
- R8: While CE is high, SCK rests at 0 when MODE3=0 and at 1 when MODE3=1. While CE is low, SI changes only on falling SCK edges, so it is stable while SCK is high.
- R9: After reset, CE is high, SCK is at its idle level, and done and timeout are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request a chip-erase sequence (taken only when idle) |
| done | output | 1 | One-cycle pulse when the sequence ends |
| timeout | output | 1 | High with done when the poll limit ended the sequence |
| sck | output | 1 | SPI serial clock |
| ce_n | output | 1 | SPI chip enable, active low |
| si | output | 1 | Serial data to the flash |
| so | input | 1 | Serial data from the flash |

## Verification
The bench builds the block with HALF_DIV=2, GAP_CYC=3, POLL_LIMIT=6, ERASE_OP=0xC7 and MODE3=0. With these values one byte takes about 34 clocks, and every sequence fits in a few hundred cycles. The small poll limit lets busy counts both below and above the limit occur often: the exact-limit case (five busy bytes, then ready) and the timeout case are directed, and random busy counts cover the rest. Choosing 0xC7 rather than the default 0x60 shows that the erase byte comes from the parameter.

// File: rtl/flash_erase_seq.sv
module flash_erase_seq #(
  parameter int HALF_DIV = 2,
  parameter int GAP_CYC = 4,
  parameter int POLL_LIMIT = 100000,
  parameter logic [7:0] ERASE_OP = 8'h60,
  parameter bit MODE3 = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic done,
  output logic timeout,
  output logic sck,
  output logic ce_n,
  output logic si,
  input  logic so
);
  localparam int DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int GW = (GAP_CYC > 1) ? $clog2(GAP_CYC) : 1;
  localparam int PW = (POLL_LIMIT > 1) ? $clog2(POLL_LIMIT) : 1;
  localparam int HW = $clog2(GAP_CYC + 1);
  localparam logic IDLE_LVL = MODE3;
  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_RDSR = 8'h05;

  typedef enum logic [2:0] {
    S_IDLE, S_WREN, S_GAP1, S_ERASE, S_GAP2, S_RDSR, S_POLL, S_TAIL
  } state_t;

  state_t state;
  logic xfer, sck_r, ce_r, done_r, tout_r, tout_pend;
  logic [DW-1:0] div_cnt;
  logic [3:0] nrise;
  logic [7:0] tx_sh, rx_sh;
  logic [GW-1:0] gap_cnt;
  logic [PW-1:0] poll_cnt;

  wire tick = xfer && (div_cnt == DW'(HALF_DIV - 1));
  wire byte_end = tick && sck_r && (nrise == 4'd8);
  wire gap_last = (gap_cnt == GW'(GAP_CYC - 1));

  assign sck = sck_r;
  assign ce_n = ce_r;
  assign si = tx_sh[7];
  assign done = done_r;
  assign timeout = tout_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      xfer <= 1'b0;
      sck_r <= IDLE_LVL;
      ce_r <= 1'b1;
      done_r <= 1'b0;
      tout_r <= 1'b0;
      tout_pend <= 1'b0;
      div_cnt <= '0;
      nrise <= '0;
      tx_sh <= '0;
      rx_sh <= '0;
      gap_cnt <= '0;
      poll_cnt <= '0;
    end else begin
      done_r <= 1'b0;
      tout_r <= 1'b0;
      if (xfer) div_cnt <= tick ? '0 : div_cnt + 1'b1;
      if (tick) begin
        if (!sck_r) begin
          sck_r <= 1'b1;
          rx_sh <= {rx_sh[6:0], so};
          nrise <= nrise + 4'd1;
        end else if (nrise == 4'd8) begin
          xfer <= 1'b0;
          sck_r <= IDLE_LVL;
        end else begin
          sck_r <= 1'b0;
          if (nrise != 4'd0) tx_sh <= {tx_sh[6:0], 1'b0};
        end
      end

      case (state)
        S_IDLE: if (start) begin
          ce_r <= 1'b0;
          xfer <= 1'b1; nrise <= '0; div_cnt <= '0; tx_sh <= OP_WREN;
          state <= S_WREN;
        end
        S_WREN: if (byte_end) begin
          ce_r <= 1'b1; gap_cnt <= '0; state <= S_GAP1;
        end
        S_GAP1: begin
          gap_cnt <= gap_cnt + 1'b1;
          if (gap_last) begin
            ce_r <= 1'b0;
            xfer <= 1'b1; nrise <= '0; div_cnt <= '0; tx_sh <= ERASE_OP;
            state <= S_ERASE;
          end
        end
        S_ERASE: if (byte_end) begin
          ce_r <= 1'b1; gap_cnt <= '0; state <= S_GAP2;
        end
        S_GAP2: begin
          gap_cnt <= gap_cnt + 1'b1;
          if (gap_last) begin
            ce_r <= 1'b0;
            xfer <= 1'b1; nrise <= '0; div_cnt <= '0; tx_sh <= OP_RDSR;
            state <= S_RDSR;
          end
        end
        S_RDSR: if (byte_end) begin
          xfer <= 1'b1; nrise <= '0; div_cnt <= '0;
          poll_cnt <= '0;
          state <= S_POLL;
        end
        S_POLL: if (byte_end) begin
          poll_cnt <= poll_cnt + 1'b1;
          if (!rx_sh[0] || poll_cnt == PW'(POLL_LIMIT - 1)) begin
            ce_r <= 1'b1;
            tout_pend <= rx_sh[0];
            gap_cnt <= '0;
            state <= S_TAIL;
          end else begin
            xfer <= 1'b1; nrise <= '0; div_cnt <= '0;
          end
        end
        S_TAIL: begin
          gap_cnt <= gap_cnt + 1'b1;
          if (gap_last) begin
            done_r <= 1'b1;
            tout_r <= tout_pend;
            state <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  logic [HW-1:0] hi_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_run <= HW'(GAP_CYC);
    else if (!ce_r) hi_run <= '0;
    else if (hi_run != HW'(GAP_CYC)) hi_run <= hi_run + 1'b1;
  end

  assert_ce_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ce_n) |-> hi_run == HW'(GAP_CYC));

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_tout_with_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> done);

  assert_idle_sck_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |-> sck == IDLE_LVL);

  assert_si_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && $past(!ce_n) && sck && $past(sck)) |-> $stable(si));
endmodule

// File: tb/flash_erase_seq_test.sv
module flash_erase_seq_test;
  localparam int LIM = 6;
  localparam int GAP = 3;
  localparam logic [7:0] EOP = 8'hC7;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic done, timeout, sck, ce_n, si, so;
  always #2 clk = ~clk;

  flash_erase_seq #(.HALF_DIV(2), .GAP_CYC(GAP), .POLL_LIMIT(LIM),
                    .ERASE_OP(EOP), .MODE3(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .done(done), .timeout(timeout),
    .sck(sck), .ce_n(ce_n), .si(si), .so(so));

  int nchk = 0, nfail = 0;
  task automatic check(string req, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // flash model
  logic [7:0] rxb = 8'h0, cur_op = 8'h0, stat = 8'h0;
  logic [7:0] ops [0:3];
  int nbits = 0, sbit = 0, ntr = 0, busy_left = 0, busy_init = 0;
  int nbytes [0:3];
  bit wel = 0, erase_ok = 0;
  logic so_r = 1'b0;
  assign so = so_r;

  always @(negedge ce_n) begin nbits = 0; sbit = 0; end
  always @(posedge sck) if (!ce_n) begin
    rxb = {rxb[6:0], si};
    nbits++;
    if (nbits == 8) begin
      cur_op = rxb;
      if (ntr < 4) ops[ntr] = rxb;
    end
  end
  always @(negedge sck) if (!ce_n && nbits >= 8 && cur_op == 8'h05) begin
    if (sbit == 0) begin
      stat = {6'b0, wel, busy_left > 0};
      if (busy_left > 0) busy_left--;
    end
    so_r = stat[7-sbit];
    sbit = (sbit + 1) % 8;
  end
  always @(posedge ce_n) begin
    if (ntr < 4) nbytes[ntr] = (nbits % 8 == 0) ? nbits / 8 : 99;
    if (nbits == 8 && cur_op == 8'h06) wel = 1;
    if (nbits == 8 && cur_op == EOP && wel) begin
      busy_left = busy_init; wel = 0; erase_ok = 1;
    end
    ntr++;
    cur_op = 8'h0;
  end

  int hcnt = 0, min_gap = 1000, idle_err = 0, ndone = 0;
  always @(negedge clk) begin
    if (ce_n) begin
      hcnt++;
      if (rst_n && sck !== 1'b0) idle_err++;
    end else begin
      if (hcnt > 0 && ntr > 0) min_gap = (hcnt < min_gap) ? hcnt : min_gap;
      hcnt = 0;
    end
    if (done) ndone++;
  end

  function automatic int exp_bytes(int b);
    return (b + 1 < LIM) ? b + 1 : LIM;
  endfunction
  function automatic int exp_tout(int b);
    return (b >= LIM) ? 1 : 0;
  endfunction

  task automatic run_seq(int b, bit poke);
    int cyc, tail, got_t;
    busy_init = b; ntr = 0; erase_ok = 0; min_gap = 1000; idle_err = 0; ndone = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    cyc = 0; tail = 0; got_t = 0;
    while (!done && cyc < 5000) begin
      @(negedge clk);
      cyc++;
      if (poke && (cyc == 40 || cyc == 120)) start = 1'b1; else start = 1'b0;
    end
    start = 1'b0;
    if (cyc >= 5000) begin
      check("R1 watchdog", 0, 1);
      return;
    end
    got_t = timeout;
    tail = hcnt;
    check("R3 tail gap", tail >= GAP, 1);
    @(negedge clk);
    check("R6 done width", done, 0);
    check("R6 timeout after done", timeout, 0);
    repeat (200) @(negedge clk);
    check("R1 transaction count", ntr, 3);
    check("R2 wren opcode", ops[0], 8'h06);
    check("R2 erase opcode", ops[1], EOP);
    check("R2 rdsr opcode", ops[2], 8'h05);
    check("R1 wren alone", nbytes[0], 1);
    check("R1 erase alone", nbytes[1], 1);
    check("R1 erase accepted", erase_ok, 1);
    check("R4 status bytes", nbytes[2] - 1, exp_bytes(b));
    check("R5 timeout flag", got_t, exp_tout(b));
    check("R3 gap", min_gap >= GAP, 1);
    check("R8 idle sck", idle_err, 0);
    check(poke ? "R7 single done" : "R6 single done", ndone, 1);
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd1234);
    repeat (3) @(negedge clk);
    check("R9 ce_n reset", ce_n, 1);
    check("R9 sck reset", sck, 0);
    check("R9 done reset", done, 0);
    check("R9 timeout reset", timeout, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    run_seq(0, 1'b0);
    run_seq(LIM - 1, 1'b0);
    run_seq(LIM, 1'b0);
    run_seq(LIM + 3, 1'b1);
    run_seq(2, 1'b1);
    for (int i = 0; i < 20; i++) run_seq($urandom % (LIM + 4), ($urandom % 3) == 0);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    #400000;
    nchk++; nfail++;
    $display("FAIL R1 watchdog expired: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule